// File: doc/BRIEF.md
# Branch Target Buffer with Return Stack

This is a fetch-stage next-PC predictor. The fetch address arrives on the lookup port. In the same cycle, with no register on the path, the block answers with a taken guess and the address to fetch next. The low word-address bits of the fetch PC select one slot of a direct-mapped table. Each slot holds a valid bit, an address tag, a target address, an entry kind and a 2-bit saturating direction counter. The stored target is used only when the tag matches in full, so the target of a different branch is never followed.

Entries marked as returns take their target from a small circular return-address stack instead of from the table. The execute stage reports each completed control-transfer instruction on a single resolve port. The report carries the instruction's PC, its outcome, its target and its kind. The block uses it to allocate or train a table slot. A call pushes its return address onto the stack and a return pops it. Every resolve update takes effect at the next rising clock edge.

Top module: `btb_predictor`

## Requirements
- R1: While `rst_ni` is low, every table slot is invalidated and the return stack is emptied. After reset and before any resolve, every lookup gives `pred_taken_o`=0 and `pred_pc_o`=`fetch_pc_i`+4.
- R2: A lookup whose slot (index `fetch_pc_i[7:2]`) is invalid, or holds a tag different from `fetch_pc_i[31:8]`, gives not taken and `fetch_pc_i`+4. This includes a PC that aliases a valid slot.
- R3: A resolve with `res_taken_i`=1 that misses the table writes the slot: valid, tag, target `res_target_i`, kind `res_kind_i` and counter 2 (weakly taken). From the next cycle, a lookup of that PC predicts taken to that target.
- R4: A resolve with `res_taken_i`=0 that misses the table changes no slot. An entry already in that slot under another tag keeps predicting as before.
- R5: On a resolve hit, the counter goes up by one if taken and down by one if not taken, saturating at 3 and at 0. For branch and call entries, a hit predicts taken to the stored target when the counter is 2 or 3. Otherwise it predicts not taken and gives PC+4.
- R6: A taken resolve that hits the table replaces the stored target with `res_target_i`.
- R7: A resolve of kind call (`res_kind_i`=2'b01) pushes `res_pc_i`+4 onto the return stack at the next edge, and is also allocated or trained as a taken entry.
- R8: A lookup that hits a return entry (kind 2'b10) always predicts taken, with the top of the return stack as the target when the stack holds data. A resolve of kind return pops the stack. Kind 2'b00 is a plain branch or jump.
- R9: When the return stack is empty, a return hit predicts the target stored in the table. A pop of an empty stack leaves it empty.
- R10: The stack holds 8 addresses. A push to a full stack overwrites the oldest one. After 9 pushes, pops return the 8 newest addresses, newest first, and the stack is then empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | Current fetch address |
| pred_taken_o | output | 1 | Taken guess for the fetch address |
| pred_pc_o | output | 32 | Predicted next fetch address |
| res_valid_i | input | 1 | A resolved control transfer is reported this cycle |
| res_pc_i | input | 32 | PC of the resolved instruction |
| res_taken_i | input | 1 | Resolved outcome |
| res_target_i | input | 32 | Resolved target address |
| res_kind_i | input | 2 | 00 branch/jump, 01 call, 10 return |

## Verification
The lookup is purely combinational. The bench sets `fetch_pc_i` a negative edge after the last update and samples the prediction 1 ns later, well before the next rising edge. A resolve is held from one negative edge to the next, so its table write and stack push or pop land on exactly one rising edge. The following lookup is then the first one that may see the change. Counter training, retargeting, aliasing, empty-stack fallback and stack wrap-around are each checked through the predicted PC, one rising edge after the resolve that should have caused them.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    KIND_BR  = 2'b00,
    KIND_CALL = 2'b01,
    KIND_RET = 2'b10
  } kind_e;

  localparam logic [1:0] CTR_ALLOC = 2'd2;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic [PC_W-1:0] lk_tgt_o,
  output logic [1:0]      lk_ctr_o,
  output logic [1:0]      lk_kind_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic [1:0]      res_kind_i
);
  import btb_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - 2;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q  [ENTRIES];
  logic [1:0]         ctr_q  [ENTRIES];
  logic [1:0]         kind_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, res_idx;
  logic [TAG_W-1:0] lk_tag, res_tag;
  logic             res_hit;

  assign lk_idx  = lk_pc_i[IDX_W+1:2];
  assign lk_tag  = lk_pc_i[PC_W-1:IDX_W+2];
  assign res_idx = res_pc_i[IDX_W+1:2];
  assign res_tag = res_pc_i[PC_W-1:IDX_W+2];

  assign lk_hit_o  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_tgt_o  = tgt_q[lk_idx];
  assign lk_ctr_o  = ctr_q[lk_idx];
  assign lk_kind_o = kind_q[lk_idx];

  assign res_hit = vld_q[res_idx] && (tag_q[res_idx] == res_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (res_valid_i && !res_hit && res_taken_i) begin
      vld_q[res_idx] <= 1'b1;
    end
  end

  // data arrays carry no reset; qualified by vld_q
  always_ff @(posedge clk_i) begin
    if (res_valid_i) begin
      if (res_hit) begin
        if (res_taken_i) begin
          ctr_q[res_idx]  <= (ctr_q[res_idx] == 2'd3) ? 2'd3 : ctr_q[res_idx] + 2'd1;
          tgt_q[res_idx]  <= res_target_i;
          kind_q[res_idx] <= res_kind_i;
        end else begin
          ctr_q[res_idx]  <= (ctr_q[res_idx] == 2'd0) ? 2'd0 : ctr_q[res_idx] - 2'd1;
        end
      end else if (res_taken_i) begin
        tag_q[res_idx]  <= res_tag;
        tgt_q[res_idx]  <= res_target_i;
        ctr_q[res_idx]  <= CTR_ALLOC;
        kind_q[res_idx] <= res_kind_i;
      end
    end
  end

  // R3
  alloc_on_taken_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_taken_i && !res_hit |=>
      vld_q[$past(res_idx)] && (tag_q[$past(res_idx)] == $past(res_tag)));

  // R4
  no_alloc_on_nt_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_taken_i && !res_hit |=> $stable(vld_q));

  // R5
  ctr_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_hit && res_taken_i && (ctr_q[res_idx] == 2'd3) |=>
      ctr_q[$past(res_idx)] == 2'd3);
endmodule

// File: rtl/btb_ras.sv
module btb_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PC_W-1:0] push_data_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] top_o,
  output logic            empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] top_q, top_inc, top_dec;
  logic [CNT_W-1:0] cnt_q;

  assign top_inc = (top_q == PTR_MAX) ? '0 : top_q + 1'b1;
  assign top_dec = (top_q == '0) ? PTR_MAX : top_q - 1'b1;
  assign top_o   = mem_q[top_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      top_q <= top_inc;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      top_q <= top_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[top_inc] <= push_data_i;
  end

  // R10
  ras_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && (cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  // R9
  ras_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && empty_o |=> empty_o);

  // R7
  ras_push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty_o && (top_o == $past(push_data_i)));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 6,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_pc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic [1:0]      res_kind_i
);
  import btb_pkg::*;

  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic            lk_hit;
  logic [PC_W-1:0] lk_tgt, ras_top, seq_pc;
  logic [1:0]      lk_ctr, lk_kind;
  logic            ras_empty, ras_push, ras_pop;

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_pc_i     (fetch_pc_i),
    .lk_hit_o    (lk_hit),
    .lk_tgt_o    (lk_tgt),
    .lk_ctr_o    (lk_ctr),
    .lk_kind_o   (lk_kind),
    .res_valid_i (res_valid_i),
    .res_pc_i    (res_pc_i),
    .res_taken_i (res_taken_i),
    .res_target_i(res_target_i),
    .res_kind_i  (res_kind_i)
  );

  assign ras_push = res_valid_i && (kind_e'(res_kind_i) == KIND_CALL);
  assign ras_pop  = res_valid_i && (kind_e'(res_kind_i) == KIND_RET);

  btb_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ras_push),
    .push_data_i(res_pc_i + INSN_BYTES),
    .pop_i      (ras_pop),
    .top_o      (ras_top),
    .empty_o    (ras_empty)
  );

  assign seq_pc = fetch_pc_i + INSN_BYTES;

  always_comb begin
    pred_taken_o = 1'b0;
    pred_pc_o    = seq_pc;
    if (lk_hit) begin
      if (kind_e'(lk_kind) == KIND_RET) begin
        pred_taken_o = 1'b1;
        pred_pc_o    = ras_empty ? lk_tgt : ras_top;
      end else if (lk_ctr[1]) begin
        pred_taken_o = 1'b1;
        pred_pc_o    = lk_tgt;
      end
    end
  end

  // R2
  nt_seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> pred_pc_o == fetch_pc_i + INSN_BYTES);

  // R8
  ret_push_then_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_push |=> (ras_top == $past(res_pc_i) + INSN_BYTES));
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        pred_taken_o;
  logic [31:0] pred_pc_o;
  logic        res_valid_i = 1'b0;
  logic [31:0] res_pc_i = '0;
  logic        res_taken_i = 1'b0;
  logic [31:0] res_target_i = '0;
  logic [1:0]  res_kind_i = 2'b00;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [1:0] K_BR = 2'b00, K_CALL = 2'b01, K_RET = 2'b10;
  localparam logic [31:0] PC_A = 32'h0000_1010;
  localparam logic [31:0] PC_R = 32'h0000_3004;
  localparam logic [31:0] T_RET = 32'h0000_9000;

  always #10 clk_i = ~clk_i;

  btb_predictor u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_pc_i  (fetch_pc_i),
    .pred_taken_o(pred_taken_o),
    .pred_pc_o   (pred_pc_o),
    .res_valid_i (res_valid_i),
    .res_pc_i    (res_pc_i),
    .res_taken_i (res_taken_i),
    .res_target_i(res_target_i),
    .res_kind_i  (res_kind_i)
  );

  task automatic look(input string req, input logic [31:0] pc,
                      input logic exp_t, input logic [31:0] exp_pc);
    fetch_pc_i = pc;
    #1;
    n_chk++;
    if (pred_taken_o !== exp_t || pred_pc_o !== exp_pc) begin
      n_fail++;
      $display("FAIL %s pc=%h got taken=%b next=%h exp taken=%b next=%h",
               req, pc, pred_taken_o, pred_pc_o, exp_t, exp_pc);
    end
  endtask

  task automatic resolve(input logic [31:0] pc, input logic taken,
                         input logic [31:0] tgt, input logic [1:0] kind);
    @(negedge clk_i);
    res_valid_i  = 1'b1;
    res_pc_i     = pc;
    res_taken_i  = taken;
    res_target_i = tgt;
    res_kind_i   = kind;
    @(negedge clk_i);
    res_valid_i  = 1'b0;
  endtask

  task automatic t_reset();
    look("R1", 32'h0000_0000, 1'b0, 32'h0000_0004);
    look("R1", PC_A, 1'b0, PC_A + 4);
    look("R1", 32'h1234_5670, 1'b0, 32'h1234_5674);
  endtask

  task automatic t_alloc();
    resolve(PC_A, 1'b1, 32'h0000_5000, K_BR);
    look("R3", PC_A, 1'b1, 32'h0000_5000);
  endtask

  task automatic t_alias();
    look("R2", PC_A + 32'h100, 1'b0, PC_A + 32'h104);
  endtask

  task automatic t_nt_miss();
    resolve(PC_A + 32'h100, 1'b0, 32'h0000_7000, K_BR);
    look("R4", PC_A, 1'b1, 32'h0000_5000);
    look("R4", PC_A + 32'h100, 1'b0, PC_A + 32'h104);
    resolve(32'h0000_1020, 1'b0, 32'h0000_7000, K_BR);
    look("R4", 32'h0000_1020, 1'b0, 32'h0000_1024);
  endtask

  task automatic t_counter();
    resolve(PC_A, 1'b0, 32'h0, K_BR);            // 2 -> 1
    look("R5", PC_A, 1'b0, PC_A + 4);
    resolve(PC_A, 1'b1, 32'h0000_5000, K_BR);    // 1 -> 2
    look("R5", PC_A, 1'b1, 32'h0000_5000);
    resolve(PC_A, 1'b1, 32'h0000_5000, K_BR);    // 3
    resolve(PC_A, 1'b1, 32'h0000_5000, K_BR);    // stays 3
    resolve(PC_A, 1'b0, 32'h0, K_BR);            // 2
    look("R5", PC_A, 1'b1, 32'h0000_5000);
    resolve(PC_A, 1'b0, 32'h0, K_BR);            // 1
    look("R5", PC_A, 1'b0, PC_A + 4);
    resolve(PC_A, 1'b0, 32'h0, K_BR);            // 0
    resolve(PC_A, 1'b0, 32'h0, K_BR);            // stays 0
    resolve(PC_A, 1'b1, 32'h0000_5000, K_BR);    // 1
    look("R5", PC_A, 1'b0, PC_A + 4);
  endtask

  task automatic t_retarget();
    resolve(PC_A, 1'b1, 32'h0000_6000, K_BR);    // 1 -> 2, new target
    look("R6", PC_A, 1'b1, 32'h0000_6000);
  endtask

  task automatic t_ret_empty();
    resolve(PC_R, 1'b1, T_RET, K_RET);
    look("R9", PC_R, 1'b1, T_RET);
  endtask

  task automatic t_call();
    resolve(32'h0000_2000, 1'b1, 32'h0000_8000, K_CALL);
    look("R7", 32'h0000_2000, 1'b1, 32'h0000_8000);
    look("R8", PC_R, 1'b1, 32'h0000_2004);
    resolve(PC_R, 1'b1, T_RET, K_RET);
    look("R9", PC_R, 1'b1, T_RET);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 9; i++)
      resolve(32'h0000_2000 + i * 32'h100, 1'b1, 32'h0000_8000, K_CALL);
    for (int k = 0; k < 8; k++) begin
      look("R10", PC_R, 1'b1, 32'h0000_2004 + (8 - k) * 32'h100);
      resolve(PC_R, 1'b1, T_RET, K_RET);
    end
    look("R10", PC_R, 1'b1, T_RET);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_alloc();
    t_alias();
    t_nt_miss();
    t_counter();
    t_retarget();
    t_ret_empty();
    t_call();
    t_overflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule